// File: doc/BRIEF.md
# Two-Channel DMA Cycle Sequencer

This block runs the word-by-word control sequence for two DMA channels. Each channel is loaded with a control word and then armed. The control word holds a device number, two end-of-transfer options (set-control and clear-control), a direction bit and a word count in two's complement. An armed channel waits for the service-request line of its chosen device. Each time that line is up, the channel runs one memory cycle, steps its count and sends the device a fixed series of one-clock command strobes. The block moves no data: a separate datapath uses `memReq`, `memCh` and `memDirIn` to make the actual memory access.

When the count wraps to zero, the channel closes out the transfer. It issues the closing commands that its options and direction call for, then raises its flag and drops its command bit. On the next clock it sends an end-of-transfer strobe. If both channels have a request pending at the same arbitration point, channel 0 is served first.

Top module: `dma_cycle_seq`

## Requirements
- R1: A channel starts a memory cycle (`memReq` high, `memCh` = channel) only while its command bit is set and the `srqIn` bit indexed by its device number is high. A request on any other device line, or a request on its own line while the channel is not armed, starts nothing.
- R2: The count loaded into `chWordCnt` is the negative of the word total. It steps up by one per memory cycle, and the transfer ends on the cycle that brings it to zero, so a count of -N gives exactly N memory cycles. Two memory cycles never fall on adjacent clocks.
- R3: After a memory cycle that is not the last one, the next clock carries STC,C if the set-control option is on and CLF if it is off.
- R4: After the last memory cycle of an input transfer (`chInput`=1), CLC is issued only if the clear-control option is on. With that option off, no command comes before the end strobe.
- R5: After the last memory cycle of an output transfer, CLF is issued if neither option is on. Otherwise STC,C is issued if set-control is on, followed by CLC,C if clear-control is on, in that order.
- R6: The channel sets its flag and clears its command bit before the end-of-transfer strobe, so the flag already reads 1 and the command bit 0 in the clock where EDT appears.
- R7: While `rstN` is low, every channel has its flag set, its command bit cleared and its control word cleared, and no strobe or memory cycle is issued. This also holds when reset arrives in the middle of a transfer.
- R8: When both channels are requesting at an arbitration point, channel 0 is granted. With both requests held high, channel 1 runs no memory cycle until channel 0 has issued its EDT.
- R9: Device commands appear as one-clock pulses on `devStb`, with the code on `devCmd` (0 = STC,C, 1 = CLF, 2 = CLC, 3 = CLC,C, 4 = EDT) and the channel's device number on `devSel`. From the last memory cycle through EDT, every event falls on consecutive clocks.
- R10: A pulse on `cmdStart[c]` sets the command bit of channel c and clears its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srqIn | input | 2**DEV_W | Service-request line of each device |
| chDevSel | input | NUM_CH*DEV_W | Device number for each channel |
| chStcOpt | input | NUM_CH | Set-control option for each channel |
| chClcOpt | input | NUM_CH | Clear-control option for each channel |
| chInput | input | NUM_CH | Direction for each channel: 1 = device to memory |
| chWordCnt | input | NUM_CH*CNT_W | Negative word count for each channel |
| cfgLoad | input | NUM_CH | Loads the control-word fields into a channel |
| cmdStart | input | NUM_CH | Arms a channel |
| memReq | output | 1 | Memory cycle request |
| memCh | output | CH_W | Channel that owns the current cycle |
| memDirIn | output | 1 | Direction of the current cycle |
| devStb | output | 1 | Device command strobe |
| devCmd | output | 3 | Device command code |
| devSel | output | DEV_W | Device addressed by the strobe |
| chFlag | output | NUM_CH | Channel flags |
| chCmd | output | NUM_CH | Channel command bits |

## Verification
A table of transfers covers every combination of direction and the two options, with word totals of one, two and three. The single-word cases show that the closing commands are chosen by whether the cycle is the last one, not by its position in the transfer. The multi-word cases separate the per-word command from the closing command. Directed runs follow the table. One raises a service request on a device the channel has not selected, and another raises a request for a channel that is loaded but not armed; both must start nothing. A further run raises requests on both channels in the same clock, to show that channel 0 wins and keeps the grant. A last run resets the block in the middle of a transfer, to show that no cycle continues afterwards.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    CMD_STCC = 3'd0,
    CMD_CLF  = 3'd1,
    CMD_CLC  = 3'd2,
    CMD_CLCC = 3'd3,
    CMD_EDT  = 3'd4
  } devCmd_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_MEM  = 3'd1,
    ST_SA   = 3'd2,
    ST_SB   = 3'd3,
    ST_EDT  = 3'd4
  } seqState_e;

  // strobes from the sequencer to the channel register bank
  typedef struct packed {
    logic incCount;
    logic finish;
  } ctrlStrb_t;

endpackage

// File: rtl/dma_seq_chan_regs.sv
module dma_seq_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int DEV_W  = 6,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [(1<<DEV_W)-1:0]   srqIn,
  input  logic [NUM_CH*DEV_W-1:0] chDevSel,
  input  logic [NUM_CH-1:0]       chStcOpt,
  input  logic [NUM_CH-1:0]       chClcOpt,
  input  logic [NUM_CH-1:0]       chInput,
  input  logic [NUM_CH*CNT_W-1:0] chWordCnt,
  input  logic [NUM_CH-1:0]       cfgLoad,
  input  logic [NUM_CH-1:0]       cmdStart,
  input  logic [CH_W-1:0]         activeCh,
  input  ctrlStrb_t               strb,
  output logic [NUM_CH-1:0]       reqVec,
  output logic [NUM_CH-1:0]       chCmd,
  output logic [NUM_CH-1:0]       chFlag,
  output logic [DEV_W-1:0]        actDev,
  output logic                    actStc,
  output logic                    actClc,
  output logic                    actIn,
  output logic                    actWrap
);

  logic [DEV_W-1:0] devArr [NUM_CH];
  logic             stcArr [NUM_CH];
  logic             clcArr [NUM_CH];
  logic             inArr  [NUM_CH];
  logic             wrapArr[NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [DEV_W-1:0] devR;
    logic             stcR;
    logic             clcR;
    logic             inR;
    logic [CNT_W-1:0] cntR;
    logic             cmdR;
    logic             flagR;
    logic             isActive;

    assign isActive = (activeCh == CH_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        devR <= '0;
        stcR <= 1'b0;
        clcR <= 1'b0;
        inR  <= 1'b0;
        cntR <= '0;
      end else if (cfgLoad[g]) begin
        devR <= chDevSel[g*DEV_W +: DEV_W];
        stcR <= chStcOpt[g];
        clcR <= chClcOpt[g];
        inR  <= chInput[g];
        cntR <= chWordCnt[g*CNT_W +: CNT_W];
      end else if (strb.incCount && isActive) begin
        cntR <= cntR + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdR  <= 1'b0;
        flagR <= 1'b1;
      end else if (strb.finish && isActive) begin
        cmdR  <= 1'b0;
        flagR <= 1'b1;
      end else if (cmdStart[g]) begin
        cmdR  <= 1'b1;
        flagR <= 1'b0;
      end
    end

    assign reqVec[g]  = cmdR & srqIn[devR];
    assign chCmd[g]   = cmdR;
    assign chFlag[g]  = flagR;
    assign devArr[g]  = devR;
    assign stcArr[g]  = stcR;
    assign clcArr[g]  = clcR;
    assign inArr[g]   = inR;
    assign wrapArr[g] = &cntR;
  end

  assign actDev  = devArr[activeCh];
  assign actStc  = stcArr[activeCh];
  assign actClc  = clcArr[activeCh];
  assign actIn   = inArr[activeCh];
  assign actWrap = wrapArr[activeCh];

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqVec,
  input  logic              actStc,
  input  logic              actClc,
  input  logic              actIn,
  input  logic              actWrap,
  output logic [CH_W-1:0]   activeCh,
  output ctrlStrb_t         strb,
  output logic              memReq,
  output logic              devStb,
  output devCmd_e           devCmd
);

  seqState_e       state, nextState;
  logic            lastR;
  logic [CH_W-1:0] grantCh;
  logic            anyReq;

  // lowest-numbered requesting channel wins
  always_comb begin
    grantCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (reqVec[i]) grantCh = CH_W'(i);
    end
  end

  assign anyReq = |reqVec;

  always_comb begin
    nextState     = state;
    memReq        = 1'b0;
    devStb        = 1'b0;
    devCmd        = CMD_CLF;
    strb.incCount = 1'b0;
    unique case (state)
      ST_IDLE: if (anyReq) nextState = ST_MEM;
      ST_MEM: begin
        memReq        = 1'b1;
        strb.incCount = 1'b1;
        if (actWrap && actIn && !actClc) nextState = ST_EDT;
        else                             nextState = ST_SA;
      end
      ST_SA: begin
        devStb = 1'b1;
        if (!lastR) begin
          devCmd    = actStc ? CMD_STCC : CMD_CLF;
          nextState = ST_IDLE;
        end else if (actIn) begin
          devCmd    = CMD_CLC;
          nextState = ST_EDT;
        end else if (actStc) begin
          devCmd    = CMD_STCC;
          nextState = actClc ? ST_SB : ST_EDT;
        end else if (actClc) begin
          devCmd    = CMD_CLCC;
          nextState = ST_EDT;
        end else begin
          devCmd    = CMD_CLF;
          nextState = ST_EDT;
        end
      end
      ST_SB: begin
        devStb    = 1'b1;
        devCmd    = CMD_CLCC;
        nextState = ST_EDT;
      end
      ST_EDT: begin
        devStb    = 1'b1;
        devCmd    = CMD_EDT;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    // flag and command bit settle one clock ahead of EDT
    strb.finish = (nextState == ST_EDT) && (state != ST_EDT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      activeCh <= '0;
      lastR    <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && anyReq) activeCh <= grantCh;
      if (state == ST_MEM) lastR <= actWrap;
    end
  end

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEV_W  = 6,
  parameter int CNT_W  = 16,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int NUM_DEV = 1 << DEV_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_DEV-1:0]      srqIn,
  input  logic [NUM_CH*DEV_W-1:0] chDevSel,
  input  logic [NUM_CH-1:0]       chStcOpt,
  input  logic [NUM_CH-1:0]       chClcOpt,
  input  logic [NUM_CH-1:0]       chInput,
  input  logic [NUM_CH*CNT_W-1:0] chWordCnt,
  input  logic [NUM_CH-1:0]       cfgLoad,
  input  logic [NUM_CH-1:0]       cmdStart,
  output logic                    memReq,
  output logic [CH_W-1:0]         memCh,
  output logic                    memDirIn,
  output logic                    devStb,
  output logic [2:0]              devCmd,
  output logic [DEV_W-1:0]        devSel,
  output logic [NUM_CH-1:0]       chFlag,
  output logic [NUM_CH-1:0]       chCmd
);

  ctrlStrb_t         strb;
  logic [NUM_CH-1:0] reqVec;
  logic [CH_W-1:0]   activeCh;
  logic              actStc, actClc, actIn, actWrap;
  devCmd_e           cmdCode;

  dma_seq_chan_regs #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DEV_W(DEV_W), .CNT_W(CNT_W)
  ) regs_i (
    .clk(clk), .rstN(rstN), .srqIn(srqIn),
    .chDevSel(chDevSel), .chStcOpt(chStcOpt), .chClcOpt(chClcOpt),
    .chInput(chInput), .chWordCnt(chWordCnt), .cfgLoad(cfgLoad),
    .cmdStart(cmdStart), .activeCh(activeCh), .strb(strb),
    .reqVec(reqVec), .chCmd(chCmd), .chFlag(chFlag), .actDev(devSel),
    .actStc(actStc), .actClc(actClc), .actIn(actIn), .actWrap(actWrap)
  );

  dma_seq_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec),
    .actStc(actStc), .actClc(actClc), .actIn(actIn), .actWrap(actWrap),
    .activeCh(activeCh), .strb(strb), .memReq(memReq),
    .devStb(devStb), .devCmd(cmdCode)
  );

  assign devCmd   = cmdCode;
  assign memCh    = activeCh;
  assign memDirIn = actIn;

endmodule

// File: rtl/dma_cycle_seq_chk.sv
module dma_cycle_seq_chk #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [CH_W-1:0]   memCh,
  input logic              devStb,
  input logic [2:0]        devCmd,
  input logic [NUM_CH-1:0] chFlag,
  input logic [NUM_CH-1:0] chCmd
);

  p_mem_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> chCmd[memCh]);

  p_mem_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  p_edt_after_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (devStb && devCmd == 3'd4) |-> (chFlag[memCh] && !chCmd[memCh]));

  p_reset_state_r7: assert property (@(posedge clk)
    !rstN |=> (&chFlag && chCmd == '0));

  p_code_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    devStb |-> devCmd <= 3'd4);

  p_edt_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    (devStb && devCmd == 3'd4) |=> !devStb);

  p_mem_vs_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !devStb);

endmodule

bind dma_cycle_seq dma_cycle_seq_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memCh(memCh),
  .devStb(devStb), .devCmd(devCmd), .chFlag(chFlag), .chCmd(chCmd)
);

// File: tb/dma_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module dma_cycle_seq_tb_top;

  localparam int NCH = 2;
  localparam int DW  = 6;
  localparam int CW  = 16;
  localparam int K_MEM = 7;
  localparam int K_EDT = 4;

  // {ch, dev[5:0], stc, clc, input, words[5:0]}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 6'd10, 1'b0, 1'b0, 1'b0, 6'd1},
    {1'b0, 6'd11, 1'b1, 1'b0, 1'b0, 6'd3},
    {1'b1, 6'd12, 1'b0, 1'b1, 1'b0, 6'd2},
    {1'b1, 6'd13, 1'b1, 1'b1, 1'b0, 6'd2},
    {1'b0, 6'd14, 1'b0, 1'b0, 1'b1, 6'd2},
    {1'b0, 6'd15, 1'b0, 1'b1, 1'b1, 6'd1},
    {1'b1, 6'd63, 1'b1, 1'b1, 1'b1, 6'd3},
    {1'b0, 6'd0,  1'b1, 1'b0, 1'b1, 6'd2}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [63:0]        srqIn = '0;
  logic [NCH*DW-1:0]  chDevSel = '0;
  logic [NCH-1:0]     chStcOpt = '0, chClcOpt = '0, chInput = '0;
  logic [NCH*CW-1:0]  chWordCnt = '0;
  logic [NCH-1:0]     cfgLoad = '0, cmdStart = '0;
  logic               memReq, memDirIn, devStb;
  logic [0:0]         memCh;
  logic [2:0]         devCmd;
  logic [DW-1:0]      devSel;
  logic [NCH-1:0]     chFlag, chCmd;

  dma_cycle_seq #(.NUM_CH(NCH), .DEV_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .srqIn(srqIn), .chDevSel(chDevSel),
    .chStcOpt(chStcOpt), .chClcOpt(chClcOpt), .chInput(chInput),
    .chWordCnt(chWordCnt), .cfgLoad(cfgLoad), .cmdStart(cmdStart),
    .memReq(memReq), .memCh(memCh), .memDirIn(memDirIn), .devStb(devStb),
    .devCmd(devCmd), .devSel(devSel), .chFlag(chFlag), .chCmd(chCmd)
  );

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  int logKind[64], logTag[64], logCyc[64], logDir[64], logFlg[64];
  int logN = 0;
  int expKind[64];
  int expN;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<=50000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // event recorder, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && logN < 64) begin
      if (memReq) begin
        logKind[logN] = K_MEM; logTag[logN] = int'(memCh);
        logCyc[logN] = cyc; logDir[logN] = int'(memDirIn);
        logFlg[logN] = int'(chFlag); logN++;
      end else if (devStb) begin
        logKind[logN] = int'(devCmd); logTag[logN] = int'(devSel);
        logCyc[logN] = cyc; logDir[logN] = 0;
        logFlg[logN] = int'(chFlag); logN++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loadCh(input int ch, input int dev, input bit stc, input bit clc,
                        input bit inp, input int words);
    tick(1);
    chDevSel[ch*DW +: DW]  = DW'(dev);
    chStcOpt[ch] = stc; chClcOpt[ch] = clc; chInput[ch] = inp;
    chWordCnt[ch*CW +: CW] = CW'(-words);
    cfgLoad[ch] = 1'b1;
    tick(1);
    cfgLoad = '0;
  endtask

  task automatic startCh(input int ch);
    cmdStart[ch] = 1'b1;
    tick(1);
    cmdStart = '0;
  endtask

  function automatic int edtSeen();
    int n = 0;
    for (int i = 0; i < logN; i++) if (logKind[i] == K_EDT) n++;
    return n;
  endfunction

  task automatic waitEdt(input int want);
    for (int i = 0; i < 300; i++) begin
      if (edtSeen() >= want) break;
      tick(1);
    end
  endtask

  // expected event list from R3, R4, R5, R6
  task automatic buildExp(input bit stc, input bit clc, input bit inp, input int words);
    expN = 0;
    for (int w = 1; w <= words; w++) begin
      expKind[expN++] = K_MEM;
      if (w < words) expKind[expN++] = stc ? 0 : 1;
      else if (inp) begin
        if (clc) expKind[expN++] = 2;
      end else if (!stc && !clc) expKind[expN++] = 1;
      else begin
        if (stc) expKind[expN++] = 0;
        if (clc) expKind[expN++] = 3;
      end
    end
    expKind[expN++] = K_EDT;
  endtask

  task automatic runVec(input logic [15:0] v);
    int ch, dev, words, memCnt, lastMem, bad;
    bit stc, clc, inp;
    ch = int'(v[15]); dev = int'(v[14:9]); stc = v[8]; clc = v[7];
    inp = v[6]; words = int'(v[5:0]);
    loadCh(ch, dev, stc, clc, inp, words);
    logN = 0;
    startCh(ch);
    srqIn[dev] = 1'b1;
    waitEdt(1);
    tick(1);
    srqIn = '0;
    buildExp(stc, clc, inp, words);
    // R3 R4 R5: command order
    bad = -1;
    for (int i = 0; i < expN; i++)
      if (bad < 0 && (i >= logN || logKind[i] != expKind[i])) bad = i;
    chk(logN == expN && bad < 0, "R3 R4 R5 sequence", bad < 0 ? logN : (bad < logN ? logKind[bad] : -1),
        bad < 0 ? expN : expKind[bad]);
    // R2: word total
    memCnt = 0; lastMem = 0;
    for (int i = 0; i < logN; i++) if (logKind[i] == K_MEM) begin memCnt++; lastMem = i; end
    chk(memCnt == words, "R2 memory cycles", memCnt, words);
    // R9: select, owner, direction, end group on consecutive clocks
    bad = 0;
    for (int i = 0; i < logN; i++) begin
      if (logKind[i] == K_MEM && (logTag[i] != ch || logDir[i] != int'(inp))) bad++;
      if (logKind[i] != K_MEM && logTag[i] != dev) bad++;
      if (i > lastMem && logCyc[i] != logCyc[lastMem] + (i - lastMem)) bad++;
    end
    chk(bad == 0, "R9 strobe fields and spacing", bad, 0);
    // R6: flag already set at EDT, command cleared afterwards
    chk(logN > 0 && logKind[logN-1] == K_EDT && logFlg[logN-1][ch] && !chCmd[ch] && chFlag[ch],
        "R6 completion", logN > 0 ? logFlg[logN-1] : -1, 1 << ch);
  endtask

  initial begin
    int firstEdt;
    int bad;
    tick(3);
    // R7: reset state
    chk(chFlag == 2'b11 && chCmd == 2'b00, "R7 reset flags", {chFlag, chCmd}, 4'b1100);
    chk(!devStb && !memReq, "R7 reset quiet", {devStb, memReq}, 0);
    rstN = 1'b1;
    tick(2);

    for (int v = 0; v < 8; v++) runVec(VEC[v]);

    // R1: wrong device line, unarmed channel
    loadCh(0, 20, 1'b0, 1'b0, 1'b0, 1);
    loadCh(1, 22, 1'b0, 1'b0, 1'b0, 1);
    logN = 0;
    startCh(0);
    chk(chCmd == 2'b01 && chFlag == 2'b10, "R10 arm", {chCmd, chFlag}, 4'b0110);
    srqIn[21] = 1'b1; srqIn[22] = 1'b1;
    tick(20);
    chk(logN == 0, "R1 no cycle without matching request", logN, 0);
    srqIn[20] = 1'b1;
    waitEdt(1);
    tick(1);
    srqIn = '0;
    chk(logN == 3 && logTag[0] == 0 && chFlag == 2'b11, "R1 matching request served", logN, 3);

    // R8: both channels request together
    loadCh(0, 30, 1'b1, 1'b0, 1'b0, 2);
    loadCh(1, 31, 1'b0, 1'b0, 1'b1, 1);
    logN = 0;
    cmdStart = 2'b11;
    tick(1);
    cmdStart = '0;
    srqIn[30] = 1'b1; srqIn[31] = 1'b1;
    waitEdt(2);
    tick(1);
    srqIn = '0;
    chk(logN > 0 && logKind[0] == K_MEM && logTag[0] == 0, "R8 first grant", logN > 0 ? logTag[0] : -1, 0);
    firstEdt = -1; bad = 0;
    for (int i = 0; i < logN; i++) begin
      if (firstEdt < 0 && logKind[i] == K_EDT) firstEdt = i;
      if (firstEdt < 0 && logKind[i] == K_MEM && logTag[i] != 0) bad++;
    end
    chk(bad == 0 && firstEdt >= 0, "R8 channel 0 keeps grant", bad, 0);
    chk(chFlag == 2'b11 && chCmd == 2'b00, "R8 both complete", {chFlag, chCmd}, 4'b1100);

    // R7: reset mid-transfer
    loadCh(1, 5, 1'b0, 1'b0, 1'b0, 8);
    startCh(1);
    srqIn[5] = 1'b1;
    tick(6);
    rstN = 1'b0;
    tick(2);
    chk(chFlag == 2'b11 && chCmd == 2'b00 && !devStb && !memReq, "R7 reset mid-transfer",
        {chFlag, chCmd, devStb, memReq}, 6'b110000);
    rstN = 1'b1;
    logN = 0;
    tick(10);
    chk(logN == 0, "R7 no activity after reset", logN, 0);
    srqIn = '0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule